// File: doc/BRIEF.md
# Strobed Parallel I/O Expansion Bus Master

This block lets a host reach many simple discrete I/O ports through a narrow external bus of 14 wires: 8 data lines, 4 address lines, a write strobe and a read strobe. The 4 address lines pick one of up to 16 external 8-bit ports, so the bus can serve up to 128 outputs and 128 inputs. Output ports are plain latches that capture the data lines while the write strobe is asserted. Input ports are plain buffers that put their value on the data lines while the read strobe is asserted. The smallest system has one output latch and one input buffer wired to the strobes directly, with no address decoding. The master's address lines sit at port 0 out of reset.

The host asks for a write with a one-cycle request, a port address and a data byte, or for a read with a request and a port address. The master then runs a fixed sequence. It sets up the address, and for a write the data, for one clock. It holds the strobe low for a programmable number of clocks. It keeps the address and data steady for one clock after the strobe returns high. It then raises a one-cycle done flag. On a read, the master stops driving the data lines and samples them on the last clock of the strobe. That byte is presented together with done. While a cycle runs, a busy flag is high and new requests are ignored.

Top module: `xbus_master`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, both strobes are high, the data drive enable is low, busy and done are low, and the address lines read 0 (the default port).
- R2: Strobes are active low, and the write strobe and read strobe are never low in the same cycle.
- R3: A request taken in idle drives the address, and for a write the data with drive enable high, in the next cycle. The strobe falls one cycle later.
- R4: After the strobe rises, the address, and for a write the data with drive enable high, stay unchanged for one further cycle.
- R5: The strobe stays low for exactly `strobe_len` consecutive clocks when `strobe_len` is 2 or more.
- R6: During a read cycle, the data drive enable stays low (the master releases the data lines).
- R7: A read returns on `rd_data` the value on `bus_din` during the last clock of the read strobe. Values present in earlier or later strobe clocks are not returned. `rd_data` is valid in the cycle in which done is high.
- R8: Busy is high from the cycle after a request is taken up to the hold cycle. Done is high for exactly one cycle, the first cycle after the hold cycle, and busy is low in that cycle.
- R9: A request that arrives while busy is high is ignored: it causes no strobe, no change of address and no further cycle.
- R10: If a write request and a read request arrive in the same idle cycle, only the write is performed.
- R11: A `strobe_len` of 0 or 1 gives a strobe of 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_wr | input | 1 | Host write request, one cycle |
| req_rd | input | 1 | Host read request, one cycle |
| req_addr | input | 4 | Port address for the request |
| req_wdata | input | 8 | Byte to write |
| strobe_len | input | 4 | Strobe width in clocks (values below 2 mean 2) |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| bus_addr | output | 4 | External address lines |
| bus_dout | output | 8 | Data driven onto the external data lines |
| bus_oe | output | 1 | High when the master drives the data lines |
| bus_din | input | 8 | Data read back from the external data lines |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |

## Verification
Take a request as seen at clock edge E0, with an effective strobe width L. Address and drive enable change at E0, the strobe is low after edges E1 through EL, the hold cycle follows edge EL+1, and done with read data follows edge EL+2. The bench drives inputs and samples outputs on falling edges. It numbers the falling edges after E0 and compares the full output vector against the value the requirements give for that index. To test read sampling, the bench changes `bus_din` from a decoy value to the target value only at the falling edge before the last strobe edge, and changes it back right after that edge.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } xbus_state_e;
endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic             req_rd,
  input  logic [LEN_W-1:0] strobe_len,
  output logic             accept,
  output logic             capture,
  output logic             wr_n,
  output logic             rd_n,
  output logic             oe,
  output logic             busy,
  output logic             done
);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

  xbus_state_e      state_q, state_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             op_wr_q, op_wr_n;
  logic             wr_n_q, wr_n_n;
  logic             rd_n_q, rd_n_n;
  logic             oe_q, oe_n;
  logic             done_q, done_n;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (strobe_len < MIN_LEN) ? MIN_LEN : strobe_len;
  assign accept  = (state_q == ST_IDLE) && (req_wr || req_rd);
  assign capture = (state_q == ST_STROBE) && (cnt_q == '0) && !op_wr_q;

  // next-state logic
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    op_wr_n = op_wr_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_n = ST_SETUP;
          op_wr_n = req_wr;
        end
      end
      ST_SETUP: begin
        state_n = ST_STROBE;
        cnt_n   = len_eff - LEN_W'(1);
      end
      ST_STROBE: begin
        if (cnt_q == '0) state_n = ST_HOLD;
        else             cnt_n   = cnt_q - LEN_W'(1);
      end
      ST_HOLD: begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
    wr_n_n = !((state_n == ST_STROBE) && op_wr_n);
    rd_n_n = !((state_n == ST_STROBE) && !op_wr_n);
    oe_n   = op_wr_n && (state_n != ST_IDLE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_wr_q <= 1'b0;
      wr_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      op_wr_q <= op_wr_n;
      wr_n_q  <= wr_n_n;
      rd_n_q  <= rd_n_n;
      oe_q    <= oe_n;
      done_q  <= done_n;
    end
  end

  assign wr_n = wr_n_q;
  assign rd_n = rd_n_q;
  assign oe   = oe_q;
  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n_q && !rd_n_q));

  p_min_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_n_q) || $fell(rd_n_q)) |=> (!wr_n_q || !rd_n_q));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
endmodule

// File: rtl/xbus_dp.sv
module xbus_dp #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] wdata_n;
  logic [DATA_W-1:0] rdata_n;

  always_comb begin
    addr_n  = load    ? addr_in  : addr_q;
    wdata_n = load    ? wdata_in : wdata_q;
    rdata_n = capture ? din      : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      rdata_q <= rdata_n;
    end
  end
endmodule

// File: rtl/xbus_master.sv
module xbus_master #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LEN_W-1:0]  strobe_len,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_wr_n,
  output logic              bus_rd_n
);
  logic rst_sync_n;
  logic accept;
  logic capture;

  xbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xbus_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_wr     (req_wr),
    .req_rd     (req_rd),
    .strobe_len (strobe_len),
    .accept     (accept),
    .capture    (capture),
    .wr_n       (bus_wr_n),
    .rd_n       (bus_rd_n),
    .oe         (bus_oe),
    .busy       (busy),
    .done       (done)
  );

  xbus_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .capture  (capture),
    .din      (bus_din),
    .addr_q   (bus_addr),
    .wdata_q  (bus_dout),
    .rdata_q  (rd_data)
  );

  p_setup_addr_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($fell(bus_wr_n) || $fell(bus_rd_n)) |-> $stable(bus_addr));

  p_setup_data_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(bus_wr_n) |-> ($past(bus_oe) && $stable(bus_dout)));

  p_hold_wr_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bus_wr_n) |-> (bus_oe && $stable(bus_addr) && $stable(bus_dout)));

  p_hold_rd_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(bus_rd_n) |-> $stable(bus_addr));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd_n |-> !bus_oe);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && $past(busy)) |-> $stable(bus_addr));
endmodule

// File: tb/xbus_master_bench.sv
module xbus_master_bench;
  logic       clk;
  logic       rst_n;
  logic       req_wr, req_rd;
  logic [3:0] req_addr;
  logic [7:0] req_wdata;
  logic [3:0] strobe_len;
  logic       busy, done;
  logic [7:0] rd_data;
  logic [3:0] bus_addr;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [7:0] bus_din;
  logic       bus_wr_n, bus_rd_n;

  int checks = 0;
  int errors = 0;

  xbus_master u_xbus_master (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata), .strobe_len(strobe_len),
    .busy(busy), .done(done), .rd_data(rd_data), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // {wr_n, rd_n, oe, busy, done, addr}
  function automatic logic [8:0] ctl();
    return {bus_wr_n, bus_rd_n, bus_oe, busy, done, bus_addr};
  endfunction

  function automatic int eff(input logic [3:0] l);
    return (l < 2) ? 2 : int'(l);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; req_wr = 0; req_rd = 0; req_addr = 0; req_wdata = 0;
    strobe_len = 4'd2; bus_din = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 in reset", {23'd0, ctl()}, {23'd0, 9'b110000000});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {23'd0, ctl()}, {23'd0, 9'b110000000});
  endtask

  task automatic issue(input logic w, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic [3:0] l);
    @(negedge clk);
    req_wr = w; req_rd = r; req_addr = a; req_wdata = d; strobe_len = l;
    @(posedge clk);
    @(negedge clk);
    req_wr = 0; req_rd = 0; req_addr = 4'hF; req_wdata = 8'h00;
  endtask

  // write cycle; on return sits at falling edge k = L+4
  task automatic t_write(input string tag, input logic [3:0] a,
                         input logic [7:0] d, input logic [3:0] l, input logic also_rd);
    int le = eff(l);
    int lows = 0;
    issue(1'b1, also_rd, a, d, l);
    for (int k = 1; k <= le + 4; k++) begin
      logic [8:0] e;
      if (k > 1) @(negedge clk);
      if (k == 1)            e = {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, a};
      else if (k <= le + 1)  e = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a};
      else if (k == le + 2)  e = {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, a};
      else if (k == le + 3)  e = {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, a};
      else                   e = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, a};
      if (!bus_wr_n) lows++;
      check({tag, " R3 R4 R8 R2 write seq"}, {23'd0, ctl()}, {23'd0, e});
      if (k <= le + 2) check({tag, " R3 R4 write data"}, {24'd0, bus_dout}, {24'd0, d});
    end
    check({tag, " R5 R11 strobe width"}, lows, le);
  endtask

  task automatic t_read(input string tag, input logic [3:0] a,
                        input logic [7:0] d, input logic [3:0] l);
    int le = eff(l);
    int lows = 0;
    bus_din = ~d;
    issue(1'b0, 1'b1, a, 8'h00, l);
    for (int k = 1; k <= le + 4; k++) begin
      logic [8:0] e;
      if (k > 1) @(negedge clk);
      if (k == 1)            e = {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, a};
      else if (k <= le + 1)  e = {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, a};
      else if (k == le + 2)  e = {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, a};
      else if (k == le + 3)  e = {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, a};
      else                   e = {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, a};
      if (!bus_rd_n) lows++;
      check({tag, " R6 R8 read seq"}, {23'd0, ctl()}, {23'd0, e});
      if (k == le + 3) check({tag, " R7 rd_data with done"}, {24'd0, rd_data}, {24'd0, d});
      if (k == le + 1) bus_din = d;
      else if (k == le + 2) bus_din = d ^ 8'h5A;
    end
    check({tag, " R5 R11 read strobe width"}, lows, le);
    check({tag, " R7 rd_data held"}, {24'd0, rd_data}, {24'd0, d});
  endtask

  task automatic t_ignore();
    int extra = 0;
    issue(1'b1, 1'b0, 4'h3, 8'hC3, 4'd3);
    // k = 1 now; raise a read request while busy
    @(negedge clk);
    req_rd = 1'b1; req_addr = 4'h9;
    @(negedge clk);
    req_rd = 1'b0;
    check("R9 addr kept while busy", {28'd0, bus_addr}, 32'h3);
    req_wr = 1'b1; req_addr = 4'hA; req_wdata = 8'h11;
    @(negedge clk);
    req_wr = 1'b0;
    check("R9 data kept while busy", {24'd0, bus_dout}, 32'hC3);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!bus_rd_n || (i > 3 && busy)) extra++;
    end
    check("R9 no extra cycle", extra, 0);
    check("R9 addr unchanged after", {28'd0, bus_addr}, 32'h3);
  endtask

  initial begin
    t_reset();
    t_write("W1", 4'h0, 8'hA5, 4'd2, 1'b0);
    t_write("W2", 4'hF, 8'h3C, 4'd5, 1'b0);
    t_write("W3 R11 len0", 4'h7, 8'hFF, 4'd0, 1'b0);
    t_write("W4 R11 len1", 4'h8, 8'h01, 4'd1, 1'b0);
    t_write("W5 R10 both", 4'h5, 8'h96, 4'd3, 1'b1);
    t_read("RD1", 4'h2, 8'h6E, 4'd2);
    t_read("RD2", 4'hC, 8'h81, 4'd7);
    t_read("RD3 R11", 4'h1, 8'h00, 4'd1);
    t_write("W6 back2back", 4'h4, 8'h42, 4'd15, 1'b0);
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule